// File: doc/BRIEF.md
# Serial Frame Transmit Engine

This block turns queued bytes into asynchronous serial frames on a single output line. It takes one-cycle pulses at sixteen times the bit rate. The block that produces those pulses also holds the programmable baud divisor, so the engine itself only counts pulses. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one, one and a half, or two high stop bits. Between frames the line rests high.

The engine pulls a byte from an external first-word-fall-through queue when it begins a frame. It signals the end of every frame with a one-cycle completion strobe. If another byte is waiting when the last stop period ends, the next start bit follows at once, without an idle gap. An active-low run input lets a controller hold the engine idle. The word length, parity mode and stop length are captured together with the byte, so each frame is sent with the settings that applied when it was taken from the queue.

The state machine has seven states: `TX_IDLE`, `TX_START`, `TX_SHIFT`, `TX_PARITY`, `TX_STOP1`, `TX_STOPH` (the half stop period) and `TX_STOP2`. Its transitions are:
- IDLE→START when the queue has data and run is asserted.
- START→SHIFT at the end of the start bit.
- SHIFT→SHIFT between data bits.
- SHIFT→PARITY or SHIFT→STOP1 after the last data bit, depending on the parity mode.
- PARITY→STOP1.
- STOP1→STOPH for 1.5 stop bits, and STOP1→STOP2 for 2 stop bits.
- From the final stop state to START when more data can go, otherwise to IDLE.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset and whenever idle with nothing to send, `tx` is 1 and `q_pop` and `frame_done` are 0.
- R2: From idle, `q_pop` pulses in the first cycle in which `q_empty` is 0 and `run_n` is 0, and the byte on `q_data` in that cycle is the one sent. `q_pop` is never 1 while `q_empty` or `run_n` is 1.
- R3: A frame starts with a low start bit, followed by the data bits least significant first. The count is set by `cfg_wlen`: 00 = 8, 01 = 7, 10 = 6, 11 = 5.
- R4: `cfg_par` 00 adds an even parity bit and 01 an odd parity bit, placed after the data bits. With even parity the data plus parity hold an even number of ones; with odd parity, an odd number. With 10 or 11 there is no parity bit.
- R5: `cfg_stop` 00 gives one stop bit, 01 gives one and a half, 10 gives two, and 11 is treated as one. Every stop bit is high.
- R6: Every full bit lasts exactly 16 `os_tick` pulses and the half stop period lasts 8. The line changes only after a tick or when a frame is taken.
- R7: `frame_done` is a one-cycle pulse in the cycle of the final tick of the last stop period, once per frame, and at no other time.
- R8: When `q_empty` and `run_n` are both 0 in the `frame_done` cycle, `q_pop` pulses in that same cycle. The next start bit then begins with no idle time.
- R9: When the queue is empty at the end of a frame, the engine goes idle and holds `tx` at 1.
- R10: `cfg_wlen`, `cfg_par` and `cfg_stop` are sampled only in the `q_pop` cycle. Changing them during a frame does not alter that frame.
- R11: While `run_n` is 1 no new frame is taken. Raising `run_n` during a frame lets that frame finish but stops any chaining after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| run_n | input | 1 | Low lets the engine start frames |
| cfg_wlen | input | 2 | Word-length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop-length code |
| q_empty | input | 1 | Transmit queue holds no byte |
| q_data | input | DATA_W | Byte at the head of the queue |
| tx | output | 1 | Serial line, idle high |
| q_pop | output | 1 | Takes the head byte at this edge |
| frame_done | output | 1 | Frame completion strobe |

## Verification
The assertions take for granted that `os_tick` is a single-cycle pulse separated by at least one idle cycle. They also assume that `q_data` stays stable while `q_empty` is low and no pop occurs, which matches a first-word-fall-through queue. The bench keeps to this: a tick divider of 3 or 5 clocks produces the ticks, and a modelled queue changes its head only on the edge after a pop.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_SHIFT,
        TX_PARITY,
        TX_STOP1,
        TX_STOPH,
        TX_STOP2
    } tx_state_e;

    localparam logic [1:0] STOP_ONE_HALF = 2'b01;
    localparam logic [1:0] STOP_TWO      = 2'b10;
    localparam logic [1:0] PAR_ODD       = 2'b01;

endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic half,
    input  logic tick,
    output logic bit_end
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

    logic [CNT_W-1:0] cnt_q;

    assign bit_end = active && tick && (cnt_q == (half ? HALF_LAST : FULL_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  nbits,
    input  logic              odd,
    output logic              par_bit
);
    always_comb begin
        logic acc;
        acc = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) begin
                acc = acc ^ data[i];
            end
        end
        par_bit = acc;
    end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              run_n,
    input  logic [1:0]        cfg_wlen,
    input  logic [1:0]        cfg_par,
    input  logic [1:0]        cfg_stop,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    output logic              tx,
    output logic              q_pop,
    output logic              frame_done
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  nbits_q;
    logic [IDX_W-1:0]  nbits_d;
    logic              par_en_q;
    logic              par_bit_q;
    logic              par_bit_d;
    logic [1:0]        stop_q;
    logic              bit_end;
    logic              start_go;
    logic              frame_end;
    logic              load;
    logic              last_data;

    assign start_go  = !q_empty && !run_n;
    assign nbits_d   = IDX_W'(DATA_W) - IDX_W'(cfg_wlen);
    assign last_data = (idx_q == nbits_q - IDX_W'(1));
    assign load      = start_go && ((state_q == TX_IDLE) || frame_end);

    uart_tx_bit_timer #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q != TX_IDLE),
        .half   (state_q == TX_STOPH),
        .tick   (os_tick),
        .bit_end(bit_end)
    );

    uart_tx_parity #(
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_parity (
        .data   (q_data),
        .nbits  (nbits_d),
        .odd    (cfg_par == PAR_ODD),
        .par_bit(par_bit_d)
    );

    // end of the last stop period of a frame
    always_comb begin
        frame_end = 1'b0;
        unique case (state_q)
            TX_STOP1:          frame_end = bit_end && (stop_q != STOP_ONE_HALF) && (stop_q != STOP_TWO);
            TX_STOPH, TX_STOP2: frame_end = bit_end;
            default:           frame_end = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (start_go) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_SHIFT;
            TX_SHIFT:  if (bit_end && last_data) state_d = par_en_q ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_end) state_d = TX_STOP1;
            TX_STOP1: begin
                if (bit_end) begin
                    if (stop_q == STOP_ONE_HALF)  state_d = TX_STOPH;
                    else if (stop_q == STOP_TWO)  state_d = TX_STOP2;
                    else                          state_d = start_go ? TX_START : TX_IDLE;
                end
            end
            TX_STOPH, TX_STOP2: if (bit_end) state_d = start_go ? TX_START : TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shr_q     <= '0;
            idx_q     <= '0;
            nbits_q   <= IDX_W'(DATA_W);
            par_en_q  <= 1'b0;
            par_bit_q <= 1'b0;
            stop_q    <= '0;
        end else if (load) begin
            shr_q     <= q_data;
            idx_q     <= '0;
            nbits_q   <= nbits_d;
            par_en_q  <= !cfg_par[1];
            par_bit_q <= par_bit_d;
            stop_q    <= cfg_stop;
        end else if (state_q == TX_SHIFT && bit_end) begin
            shr_q <= shr_q >> 1;
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_START:  tx = 1'b0;
            TX_SHIFT:  tx = shr_q[0];
            TX_PARITY: tx = par_bit_q;
            default:   tx = 1'b1;
        endcase
        q_pop      = load;
        frame_done = frame_end;
    end
endmodule

module uart_tx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic os_tick,
    input logic run_n,
    input logic q_empty,
    input logic tx,
    input logic q_pop,
    input logic frame_done
);
    // R2
    pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (!q_empty && !run_n));
    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !tx);
    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(os_tick) && !$past(q_pop)) |-> $stable(tx));
    // R7
    done_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> os_tick);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R8
    chain_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !q_empty && !run_n) |-> q_pop);
    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && (q_empty || run_n)) |=> tx);
endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_tick   (os_tick),
    .run_n     (run_n),
    .q_empty   (q_empty),
    .tx        (tx),
    .q_pop     (q_pop),
    .frame_done(frame_done)
);

// File: tb/uart_tx_engine_bench.sv
`timescale 1ns/1ps
module uart_tx_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       run_n = 1'b0;
    logic [1:0] cfg_wlen = 2'b00;
    logic [1:0] cfg_par = 2'b10;
    logic [1:0] cfg_stop = 2'b00;
    logic       q_empty = 1'b1;
    logic [7:0] q_data = 8'h00;
    logic       tx, q_pop, frame_done;

    int checks = 0;
    int errors = 0;

    // queue model
    logic [7:0] qmem [16];
    int qh = 0;
    int qn = 0;

    // tick generator
    int tdiv = 3;
    int tcnt = 0;

    // sampled outputs
    logic c_tx, c_pop, c_done, c_tick;
    int   pops = 0;

    // frame monitor
    bit         fr_act = 0;
    int         fr_t = 0;
    int         fr_total = 0;
    logic [7:0] fr_data;
    logic [1:0] fr_wl, fr_par, fr_stop;
    bit         fr_bad = 0;
    int         fr_bad_act = 0;
    int         fr_bad_exp = 0;
    string      fr_tag = "R3";
    int         frames_done = 0;

    always #2.5 clk = ~clk;

    uart_tx_engine u_uart_tx_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (tick),
        .run_n     (run_n),
        .cfg_wlen  (cfg_wlen),
        .cfg_par   (cfg_par),
        .cfg_stop  (cfg_stop),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .tx        (tx),
        .q_pop     (q_pop),
        .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(logic [7:0] d, logic [1:0] wl, logic [1:0] par, int t);
        int n;
        int slot;
        logic p;
        n = 8 - int'(wl);
        slot = (t - 1) / 16;
        if (slot == 0) return 1'b0;
        if (slot <= n) return d[slot-1];
        if (!par[1] && slot == n + 1) begin
            p = par[0];
            for (int i = 0; i < n; i++) p = p ^ d[i];
            return p;
        end
        return 1'b1;
    endfunction

    function automatic int frame_ticks(logic [1:0] wl, logic [1:0] par, logic [1:0] stp);
        int n;
        n = 8 - int'(wl);
        return 16 * (2 + n + (par[1] ? 0 : 1)) + (stp == 2'b01 ? 8 : (stp == 2'b10 ? 16 : 0));
    endfunction

    task automatic drive_q();
        q_empty = (qn == 0);
        q_data  = qmem[qh % 16];
    endtask

    task automatic push(input logic [7:0] b);
        qmem[(qh + qn) % 16] = b;
        qn++;
        drive_q();
    endtask

    task automatic step();
        logic exp;
        @(negedge clk);
        c_tx = tx; c_pop = q_pop; c_done = frame_done; c_tick = tick;
        if (fr_act && c_tick) begin
            fr_t++;
            exp = exp_bit(fr_data, fr_wl, fr_par, fr_t);
            if (c_tx !== exp && !fr_bad) begin
                fr_bad = 1; fr_bad_act = int'(c_tx); fr_bad_exp = int'(exp);
            end
            if (fr_t == fr_total) begin
                chk(!fr_bad, fr_tag, "frame bit sequence", fr_bad_act, fr_bad_exp);
                chk(c_done == 1'b1, "R7", "done at final stop tick", int'(c_done), 1);
                if (qn > 0 && !run_n) chk(c_pop == 1'b1, "R8", "chained pop with done", int'(c_pop), 1);
                fr_act = 0;
                frames_done++;
            end else if (c_done) begin
                chk(0, "R7", "done before frame end", fr_t, fr_total);
            end
        end else if (c_done) begin
            chk(0, "R7", "done outside a frame", 1, 0);
        end
        if (c_pop) begin
            pops++;
            if (qn == 0 || run_n) chk(0, "R2", "pop while not allowed", 1, 0);
            fr_data = qmem[qh % 16];
            fr_wl = cfg_wlen; fr_par = cfg_par; fr_stop = cfg_stop;
            fr_total = frame_ticks(cfg_wlen, cfg_par, cfg_stop);
            fr_t = 0; fr_act = 1; fr_bad = 0;
        end
        @(posedge clk);
        #1;
        if (c_pop) begin
            qh++; qn--;
            drive_q();
        end
        tcnt = (tcnt + 1) % tdiv;
        tick = (tcnt == 0);
    endtask

    task automatic wait_frames(input int target);
        while (frames_done < target) step();
        step();
    endtask

    task automatic t_reset();
        for (int i = 0; i < 10; i++) step();
        chk(c_tx == 1'b1, "R1", "tx idle high", int'(c_tx), 1);
        chk(c_pop == 1'b0, "R1", "no pop when empty", int'(c_pop), 0);
        chk(c_done == 1'b0, "R1", "no done when idle", int'(c_done), 0);
    endtask

    task automatic t_basic();
        int target;
        fr_tag = "R3"; cfg_wlen = 2'b00; cfg_par = 2'b10; cfg_stop = 2'b00;
        target = frames_done + 1;
        push(8'hA5);
        step();
        chk(c_pop == 1'b1, "R2", "pop one cycle after data", int'(c_pop), 1);
        wait_frames(target);
        for (int i = 0; i < 40; i++) step();
        chk(c_tx == 1'b1, "R9", "line high after frame", int'(c_tx), 1);
        chk(fr_act == 0 && c_pop == 0, "R9", "engine idle after frame", int'(c_pop), 0);
    endtask

    task automatic t_wordlen();
        logic [7:0] pat [4] = '{8'h3C, 8'hD3, 8'h2B, 8'h96};
        fr_tag = "R3"; cfg_par = 2'b10; cfg_stop = 2'b00;
        for (int w = 1; w < 4; w++) begin
            int target;
            cfg_wlen = 2'(w);
            target = frames_done + 1;
            push(pat[w]);
            wait_frames(target);
        end
    endtask

    task automatic t_parity();
        int target;
        fr_tag = "R4"; cfg_stop = 2'b00;
        cfg_wlen = 2'b00; cfg_par = 2'b00;
        target = frames_done + 1; push(8'hB1); wait_frames(target);
        cfg_par = 2'b01;
        target = frames_done + 1; push(8'hB1); wait_frames(target);
        cfg_wlen = 2'b11; cfg_par = 2'b00;
        target = frames_done + 1; push(8'hE7); wait_frames(target);
        cfg_wlen = 2'b01; cfg_par = 2'b01;
        target = frames_done + 1; push(8'h80); wait_frames(target);
        cfg_wlen = 2'b00; cfg_par = 2'b11;
        target = frames_done + 1; push(8'h0F); wait_frames(target);
    endtask

    task automatic t_stop();
        fr_tag = "R5"; cfg_wlen = 2'b10; cfg_par = 2'b00;
        for (int s = 1; s < 4; s++) begin
            int target;
            cfg_stop = 2'(s);
            target = frames_done + 1;
            push(8'h5A);
            wait_frames(target);
        end
    endtask

    task automatic t_rate();
        int target;
        fr_tag = "R6"; tdiv = 5; cfg_wlen = 2'b00; cfg_par = 2'b01; cfg_stop = 2'b01;
        target = frames_done + 1; push(8'hC4); wait_frames(target);
        tdiv = 3;
    endtask

    task automatic t_chain();
        int target;
        fr_tag = "R8"; cfg_wlen = 2'b00; cfg_par = 2'b00; cfg_stop = 2'b01;
        target = frames_done + 3;
        push(8'h11); push(8'hEE); push(8'h72);
        wait_frames(target);
        chk(qn == 0, "R8", "all queued bytes sent", qn, 0);
    endtask

    task automatic t_cfg_change();
        int target;
        fr_tag = "R10"; cfg_wlen = 2'b00; cfg_par = 2'b00; cfg_stop = 2'b10;
        target = frames_done + 1;
        push(8'h69);
        while (!(fr_act && fr_t > 20)) step();
        cfg_wlen = 2'b11; cfg_par = 2'b10; cfg_stop = 2'b00;
        wait_frames(target);
    endtask

    task automatic t_run();
        int p0;
        int target;
        fr_tag = "R11"; cfg_wlen = 2'b00; cfg_par = 2'b10; cfg_stop = 2'b00;
        run_n = 1'b1;
        p0 = pops;
        push(8'h4D);
        for (int i = 0; i < 300; i++) step();
        chk(pops == p0, "R11", "no pop while held", pops - p0, 0);
        chk(c_tx == 1'b1, "R11", "line high while held", int'(c_tx), 1);
        run_n = 1'b0;
        target = frames_done + 1;
        step();
        chk(c_pop == 1'b1, "R11", "pop after release", int'(c_pop), 1);
        push(8'h9A);
        while (!(fr_act && fr_t > 40)) step();
        run_n = 1'b1;
        wait_frames(target);
        p0 = pops;
        for (int i = 0; i < 200; i++) step();
        chk(pops == p0, "R11", "no chaining while held", pops - p0, 0);
        chk(c_tx == 1'b1, "R11", "idle high after held frame", int'(c_tx), 1);
        target = frames_done + 1;
        run_n = 1'b0;
        wait_frames(target);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, -1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive_q();
        for (int i = 0; i < 4; i++) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wordlen();
        t_parity();
        t_stop();
        t_rate();
        t_chain();
        t_cfg_change();
        t_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule